// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces the refresh traffic of an SDRAM controller. A 2-bit rate code picks the refresh interval, or switches refresh off. A 2-bit bus-frequency select says how many bus clocks make up that interval. A free-running interval counter produces one refresh tick per interval.

Each tick adds one to a count of refreshes that the controller still owes. The request output is a level. It stays high while that count is nonzero. Every one-cycle acknowledge from the controller pays one refresh back.

A controller that is busy for several intervals loses no refresh, because the owed count holds up to eight. A further tick while eight are owed sets a sticky error flag that only reset clears. Any change to the rate or frequency code restarts the interval from zero.

Top module: `sdram_refresh_timer`

## Requirements
- R1: Rate code 2'b00 disables refresh. While it is applied, the interval counter stays at zero and no tick occurs. The owed count is cleared at the next clock edge, so the request is low from the following cycle. Acknowledges are ignored.
- R2: The interval length L in clocks is floor(T*F/10). T is in tenths of a microsecond: 78 for rate 2'b01, 156 for 2'b10 and 1250 for 2'b11. F is in MHz: 66 for select 2'b00, 100 for 2'b01 and 133 for 2'b10 or 2'b11. The first tick comes at the L-th clock edge after the edge that restarted the counter.
- R3: If the rate or frequency code differs from its value at the previous edge, the counter returns to zero at that edge. A full interval L then follows.
- R4: The request is high exactly while the owed count (`pend_cnt`) is nonzero. An acknowledge with no tick in the same cycle lowers the count by one at that edge.
- R5: Ticks that are not acknowledged add up in `pend_cnt`, to at most 8. The request stays high throughout.
- R6: A tick with no acknowledge while 8 refreshes are owed sets `ovf_err` and leaves the count at 8. `ovf_err` stays set until reset, even after the count drains.
- R7: A tick and an acknowledge at the same edge leave the owed count unchanged.
- R8: An acknowledge while the owed count is zero has no effect. The count stays 0 and the request stays low.
- R9: After reset, the request is low, the owed count is 0 and the error flag is clear.
- R10: Ticks repeat every L clocks whether or not acknowledges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 2 | Refresh interval code (00 off, 01 7.8 us, 10 15.6 us, 11 125 us) |
| freq_sel | input | 2 | Bus clock select (00 66 MHz, 01 100 MHz, 1x 133 MHz) |
| ref_ack | input | 1 | One-cycle acknowledge of one refresh |
| ref_req | output | 1 | Refresh request level |
| pend_cnt | output | 4 | Number of owed refreshes |
| ovf_err | output | 1 | Sticky overflow of the owed count |

## Verification
A tick and an acknowledge can fall on the same clock edge. The bench provokes this by asserting the acknowledge exactly one cycle before a computed tick edge, while one refresh is owed. It judges the result by the owed count: it must still read 1, and the request must not fall and rise again. A second coincidence is a tick arriving while eight refreshes are owed. The bench checks that the flag stays clear one cycle before that tick and is set right after it.

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int MHZ_LO   = 66,
  parameter int MHZ_MID  = 100,
  parameter int MHZ_HI   = 133,
  parameter int T_SHORT  = 78,
  parameter int T_MID    = 156,
  parameter int T_LONG   = 1250,
  parameter int PEND_MAX = 8,
  localparam int CW = $clog2(T_LONG * MHZ_HI / 10 + 1),
  localparam int PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rate_code,
  input  logic [1:0]    freq_sel,
  input  logic          ref_ack,
  output logic          ref_req,
  output logic [PW-1:0] pend_cnt,
  output logic          ovf_err
);

  function automatic logic [CW-1:0] interval_clocks(input logic [1:0] r, input logic [1:0] f);
    int t, m;
    case (r)
      2'b01:   t = T_SHORT;
      2'b10:   t = T_MID;
      default: t = T_LONG;
    endcase
    case (f)
      2'b00:   m = MHZ_LO;
      2'b01:   m = MHZ_MID;
      default: m = MHZ_HI;
    endcase
    return CW'((t * m) / 10);
  endfunction

  logic [CW-1:0] cnt;
  logic [1:0]    rate_q, freq_q;
  logic          off, code_chg, tick, ack_eff;
  logic [CW-1:0] limit;

  assign off      = (rate_code == 2'b00);
  assign code_chg = (rate_code != rate_q) || (freq_sel != freq_q);
  assign limit    = interval_clocks(rate_code, freq_sel);
  assign tick     = !off && !code_chg && (cnt == limit - 1'b1);
  assign ack_eff  = ref_ack && (pend_cnt != '0) && !off;
  assign ref_req  = (pend_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= 2'b00;
      freq_q <= 2'b00;
      cnt    <= '0;
    end else begin
      rate_q <= rate_code;
      freq_q <= freq_sel;
      if (off || code_chg || tick) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      ovf_err  <= 1'b0;
    end else if (off) begin
      pend_cnt <= '0;
    end else if (tick && !ack_eff) begin
      if (pend_cnt == PW'(PEND_MAX)) ovf_err <= 1'b1;
      else                           pend_cnt <= pend_cnt + 1'b1;
    end else if (ack_eff && !tick) begin
      pend_cnt <= pend_cnt - 1'b1;
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (pend_cnt == '0));  // R1
  AST_CODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    code_chg |=> (cnt == '0));  // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack && !off) |=> ref_req);  // R4
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PEND_MAX));  // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);  // R6

endmodule

// File: tb/sim_sdram_refresh_timer.sv
module sim_sdram_refresh_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] rate_code = 2'b01;
  logic [1:0] freq_sel = 2'b00;
  logic       ref_ack = 0;
  logic       ref_req;
  logic [3:0] pend_cnt;
  logic       ovf_err;

  int total = 0, bad = 0, cyc = 0;
  int exp_q[$];
  logic prev_req = 0;

  sdram_refresh_timer u0 (.clk(clk), .rst_n(rst_n), .rate_code(rate_code), .freq_sel(freq_sel),
    .ref_ack(ref_ack), .ref_req(ref_req), .pend_cnt(pend_cnt), .ovf_err(ovf_err));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lim(input logic [1:0] r, input logic [1:0] f);
    int t, m;
    t = (r == 2'b01) ? 78 : (r == 2'b10) ? 156 : 1250;
    m = (f == 2'b00) ? 66 : (f == 2'b01) ? 100 : 133;
    return (t * m) / 10;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // monitor: every rising request must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && ref_req && !prev_req) begin
      if (exp_q.size() == 0) check("R1/R2 unexpected request", cyc, -1);
      else check("R2 request rise cycle", cyc, exp_q.pop_front());
    end
    prev_req <= ref_req;
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic set_codes(input logic [1:0] r, input logic [1:0] f, output int rise);
    rate_code = r; freq_sel = f;
    rise = cyc + 1 + lim(r, f);
    exp_q.push_back(rise);
  endtask

  task automatic ack_once;
    ref_ack = 1; @(negedge clk); ref_ack = 0;
  endtask

  task automatic run_freq(input logic [1:0] r, input logic [1:0] f);
    int rise;
    set_codes(r, f, rise);
    wait_to(rise);
    check("R2 owed count at tick", pend_cnt, 1);
    ack_once();
    check("R4 request drops after ack", ref_req, 0);
  endtask

  task automatic run_all;
    int r, r2, r3, c;
    repeat (3) @(negedge clk);
    check("R9 reset request", ref_req, 0);
    check("R9 reset owed count", pend_cnt, 0);
    check("R9 reset error", ovf_err, 0);
    rst_n = 1;
    r = cyc + 1 + 514;
    exp_q.push_back(r);
    wait_to(r);
    check("R2 request at 7.8us/66MHz", ref_req, 1);
    ack_once();
    check("R4 owed count after ack", pend_cnt, 0);
    check("R4 request low after ack", ref_req, 0);
    r2 = r + 514;
    exp_q.push_back(r2);                          // R10 periodic
    wait_to(r2);
    check("R10 second tick owed", pend_cnt, 1);
    ack_once();
    ack_once();                                   // R8 ack at zero
    check("R8 owed stays zero", pend_cnt, 0);
    check("R8 request stays low", ref_req, 0);
    r3 = r2 + 514;
    exp_q.push_back(r3);
    wait_to(r3);
    wait_to(r3 + 513);
    ref_ack = 1;                                  // R7 coincides with tick at r3+514
    @(negedge clk); ref_ack = 0;
    check("R7 tick and ack together", pend_cnt, 1);
    check("R7 request held", ref_req, 1);
    ack_once();
    check("R7 drained", pend_cnt, 0);
    // R2 frequencies and rates
    run_freq(2'b01, 2'b01);
    run_freq(2'b01, 2'b10);
    run_freq(2'b01, 2'b11);
    run_freq(2'b10, 2'b00);
    run_freq(2'b11, 2'b10);
    // R3 restart mid-interval
    set_codes(2'b01, 2'b00, r);
    void'(exp_q.pop_back());
    wait_to(cyc + 300);
    set_codes(2'b01, 2'b01, r);
    wait_to(r);
    check("R3 restart gives full interval", pend_cnt, 1);
    // R1 disable with a refresh owed
    rate_code = 2'b00;
    @(negedge clk);
    check("R1 owed cleared when off", pend_cnt, 0);
    check("R1 request low when off", ref_req, 0);
    ack_once();
    wait_to(cyc + 20000);
    check("R1 no requests while off", ref_req, 0);
    // R5 / R6 accumulation and overflow
    set_codes(2'b01, 2'b00, r);
    wait_to(r + 2 * 514);
    check("R5 three owed", pend_cnt, 3);
    check("R5 request high", ref_req, 1);
    wait_to(r + 7 * 514);
    check("R5 eight owed", pend_cnt, 8);
    wait_to(r + 8 * 514 - 1);
    check("R6 no error yet", ovf_err, 0);
    @(negedge clk);
    check("R6 overflow flag", ovf_err, 1);
    check("R6 count saturates", pend_cnt, 8);
    ref_ack = 1;
    repeat (8) @(negedge clk);
    ref_ack = 0;
    check("R6 drained count", pend_cnt, 0);
    check("R6 flag sticky", ovf_err, 1);
    rate_code = 2'b00;
    repeat (2) @(negedge clk);
    check("R6 flag sticky while off", ovf_err, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
      end
    join_any
    disable fork;
    check("R2 all expected requests seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule